// File: doc/BRIEF.md
# Programmable Local Bus Cycle Sequencer

This block turns a single request from the host side into one complete access on a legacy peripheral bus. The request carries a target address, a direction, write data and the index of one of four peripheral selects. The sequencer drives the address, the select, the strobes and the outgoing data, walks through a setup phase, a strobe phase, a hold phase and (for writes) a data hold phase, and then returns read data with a one-cycle completion pulse. All timing counts whole cycles of the host clock, and every phase length comes from its own configuration field.

Two strobe conventions can be chosen at run time. In the separate-strobe convention, the four selects frame the access and distinct active-low read and write strobes mark the transfer. In the data-strobe convention, the selects themselves become active-low data strobes, the write strobe pin becomes an active-low read/write direction line, and the read strobe pin stays inactive. A build parameter picks a narrow bus (8-bit data, 8-bit address) or a wide bus (32-bit data, 12-bit address). The data bus leaves the block as separate output, output-enable and input vectors, for the pad ring to combine into one bidirectional bus.

The controller has five states: IDLE, SETUP, STROBE, HOLD and DHOLD. The transitions are: IDLE to SETUP on an accepted request when the setup field is non-zero, and IDLE to STROBE when it is zero. SETUP goes to STROBE when its count runs out. STROBE goes to HOLD if the hold field is non-zero, else to DHOLD if the access is a write with a non-zero data hold field, else to IDLE. HOLD goes to DHOLD under the same data hold condition, else to IDLE. DHOLD goes to IDLE. The completion pulse marks each return to IDLE.

Top module: `lbus_seq`

## Requirements
- R1: After reset the block is idle: busy and done are 0, rd_data is 0, all four selects and both strobe pins are high, and the data output enable equals cfg_idle_drive.
- R2: A request (req_valid high at a rising edge) is accepted only while idle. busy is high from the cycle after acceptance up to the completion cycle. In the completion cycle busy is 0 and done is 1 for exactly one cycle. A request presented while busy has no effect. A request held through the completion cycle is accepted at that cycle's edge.
- R3: An access lasts cfg_setup setup cycles, then a strobe of cfg_rd_len (read) or cfg_wr_len (write) cycles, with a zero field meaning one cycle, then cfg_hold hold cycles, then, for writes only, cfg_dhold data hold cycles. A zero setup, hold or data hold field removes that phase.
- R4: With cfg_moto=0, select lb_cs_n[req_sel] is low during the setup, strobe and hold phases and high otherwise. lb_rd_n is low only in the strobe phase of a read, and lb_wr_n only in the strobe phase of a write. The other selects stay high.
- R5: With cfg_moto=1, lb_cs_n[req_sel] is low only during the strobe phase. lb_wr_n is a direction line: low (write) during the setup, strobe and hold phases of a write, and high otherwise. lb_rd_n stays high.
- R6: When idle, including between two back-to-back accesses, all selects and both strobe pins are high, so at least one idle cycle separates any two accesses.
- R7: A read captures lb_data_i at the rising edge that ends the last strobe cycle. rd_data holds that value until the next read completes, and is unchanged by writes.
- R8: During a write, lb_data_oe is 1 and lb_data_o carries the request's write data in every busy cycle, through the end of the data hold phase. During a read, lb_data_oe is 0 in every busy cycle.
- R9: While idle, lb_data_oe equals cfg_idle_drive. When it is 1, lb_data_o carries the most recently written data (0 if none).
- R10: lb_addr is loaded at acceptance with the request address, with every bit at position cfg_win or above forced to 0. It holds that value while busy and after completion, until the next acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock; all timing counts its cycles |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data |
| req_sel | input | 2 | Index of the select to use |
| cfg_moto | input | 1 | 1 = data-strobe convention, 0 = separate strobes |
| cfg_idle_drive | input | 1 | 1 = drive the data bus while idle |
| cfg_win | input | 4 | Number of low address bits passed through |
| cfg_setup | input | TW | Address/select setup cycles |
| cfg_rd_len | input | TW | Read strobe cycles |
| cfg_wr_len | input | TW | Write strobe cycles |
| cfg_hold | input | TW | Address/select hold cycles |
| cfg_dhold | input | TW | Write data hold cycles |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DW | Last captured read data |
| lb_addr | output | AW | Peripheral address |
| lb_cs_n | output | 4 | Active-low selects / data strobes |
| lb_rd_n | output | 1 | Active-low read strobe |
| lb_wr_n | output | 1 | Active-low write strobe / read-write line |
| lb_data_o | output | DW | Data bus output value |
| lb_data_oe | output | 1 | Data bus output enable |
| lb_data_i | input | DW | Data bus input value |

## Verification
The completion of one access and the acceptance of the next can fall in the same cycle. When req_valid is already high as done pulses, the IDLE state at that edge must both report completion and launch the new access. The bench provokes this by issuing its randomized accesses back to back, placing each new request in the completion cycle of the previous one. It judges the overlap by checking that the completion cycle shows every select and strobe inactive and the old address still present, and that the very next cycle carries the new address and the new phase sequence. Requests pushed in during busy cycles check that this overlap is confined to the idle cycle.

// File: rtl/lbus_pkg.sv
package lbus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_DHOLD
    } lbus_state_e;

endpackage

// File: rtl/lbus_fsm.sv
module lbus_fsm
    import lbus_pkg::*;
#(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          req_write,
    input  logic [TW-1:0] cfg_setup,
    input  logic [TW-1:0] cfg_rd_len,
    input  logic [TW-1:0] cfg_wr_len,
    input  logic [TW-1:0] cfg_hold,
    input  logic [TW-1:0] cfg_dhold,
    output lbus_state_e   state,
    output logic          wr_q,
    output logic          capture,
    output logic          done
);

    lbus_state_e   nxt;
    logic [TW-1:0] cnt, cnt_nxt;
    logic          wr_eff;
    logic [TW-1:0] stb_len, dh_len;

    // phase lengths for the access being started or in progress
    always_comb begin
        wr_eff  = (state == ST_IDLE) ? req_write : wr_q;
        stb_len = wr_eff ? cfg_wr_len : cfg_rd_len;
        if (stb_len == '0) stb_len = TW'(1);
        dh_len  = wr_eff ? cfg_dhold : '0;
    end

    always_comb begin
        nxt     = state;
        cnt_nxt = cnt;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    if (cfg_setup != '0) begin
                        nxt     = ST_SETUP;
                        cnt_nxt = cfg_setup - TW'(1);
                    end else begin
                        nxt     = ST_STROBE;
                        cnt_nxt = stb_len - TW'(1);
                    end
                end
            end
            ST_SETUP: begin
                if (cnt == '0) begin
                    nxt     = ST_STROBE;
                    cnt_nxt = stb_len - TW'(1);
                end else begin
                    cnt_nxt = cnt - TW'(1);
                end
            end
            ST_STROBE: begin
                if (cnt == '0) begin
                    if (cfg_hold != '0) begin
                        nxt     = ST_HOLD;
                        cnt_nxt = cfg_hold - TW'(1);
                    end else if (dh_len != '0) begin
                        nxt     = ST_DHOLD;
                        cnt_nxt = dh_len - TW'(1);
                    end else begin
                        nxt = ST_IDLE;
                    end
                end else begin
                    cnt_nxt = cnt - TW'(1);
                end
            end
            ST_HOLD: begin
                if (cnt == '0) begin
                    if (dh_len != '0) begin
                        nxt     = ST_DHOLD;
                        cnt_nxt = dh_len - TW'(1);
                    end else begin
                        nxt = ST_IDLE;
                    end
                end else begin
                    cnt_nxt = cnt - TW'(1);
                end
            end
            ST_DHOLD: begin
                if (cnt == '0) nxt = ST_IDLE;
                else           cnt_nxt = cnt - TW'(1);
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            wr_q  <= 1'b0;
            done  <= 1'b0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
            done  <= (state != ST_IDLE) && (nxt == ST_IDLE);
            if (start) wr_q <= req_write;
        end
    end

    assign capture = (state == ST_STROBE) && (cnt == '0) && !wr_q;

endmodule

// File: rtl/lbus_addr.sv
module lbus_addr #(
    parameter int AW   = 12,
    parameter int WINW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [AW-1:0]   req_addr,
    input  logic [WINW-1:0] cfg_win,
    output logic [AW-1:0]   addr_q
);

    logic [AW-1:0] keep;

    // bits at or above the window width are cleared
    for (genvar i = 0; i < AW; i++) begin : g_mask
        assign keep[i] = (int'(cfg_win) > i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     addr_q <= '0;
        else if (start) addr_q <= req_addr & keep;
    end

endmodule

// File: rtl/lbus_pins.sv
module lbus_pins
    import lbus_pkg::*;
#(
    parameter int NCS = 4,
    parameter int CSW = 2,
    parameter int DW  = 32
) (
    input  lbus_state_e    state,
    input  logic           wr_q,
    input  logic [CSW-1:0] sel_q,
    input  logic           cfg_moto,
    input  logic           cfg_idle_drive,
    input  logic [DW-1:0]  wdata_q,
    output logic [NCS-1:0] lb_cs_n,
    output logic           lb_rd_n,
    output logic           lb_wr_n,
    output logic [DW-1:0]  lb_data_o,
    output logic           lb_data_oe
);

    logic [NCS-1:0] sel_low;

    assign sel_low   = ~(NCS'(1) << sel_q);
    assign lb_data_o = wdata_q;

    always_comb begin
        lb_cs_n    = '1;
        lb_rd_n    = 1'b1;
        lb_wr_n    = 1'b1;
        lb_data_oe = wr_q;
        unique case (state)
            ST_IDLE: begin
                lb_data_oe = cfg_idle_drive;
            end
            ST_SETUP, ST_HOLD: begin
                if (!cfg_moto) lb_cs_n = sel_low;
                else           lb_wr_n = !wr_q;
            end
            ST_STROBE: begin
                lb_cs_n = sel_low;
                if (cfg_moto) begin
                    lb_wr_n = !wr_q;
                end else begin
                    lb_rd_n = wr_q;
                    lb_wr_n = !wr_q;
                end
            end
            ST_DHOLD: begin
                lb_data_oe = 1'b1;
            end
            default: lb_data_oe = cfg_idle_drive;
        endcase
    end

endmodule

// File: rtl/lbus_seq.sv
module lbus_seq
    import lbus_pkg::*;
#(
    parameter bit WIDE = 1'b1,
    parameter int TW   = 4,
    parameter int NCS  = 4,
    parameter int DW   = WIDE ? 32 : 8,
    parameter int AW   = WIDE ? 12 : 8,
    parameter int CSW  = $clog2(NCS),
    parameter int WINW = $clog2(AW + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            req_write,
    input  logic [AW-1:0]   req_addr,
    input  logic [DW-1:0]   req_wdata,
    input  logic [CSW-1:0]  req_sel,
    input  logic            cfg_moto,
    input  logic            cfg_idle_drive,
    input  logic [WINW-1:0] cfg_win,
    input  logic [TW-1:0]   cfg_setup,
    input  logic [TW-1:0]   cfg_rd_len,
    input  logic [TW-1:0]   cfg_wr_len,
    input  logic [TW-1:0]   cfg_hold,
    input  logic [TW-1:0]   cfg_dhold,
    output logic            busy,
    output logic            done,
    output logic [DW-1:0]   rd_data,
    output logic [AW-1:0]   lb_addr,
    output logic [NCS-1:0]  lb_cs_n,
    output logic            lb_rd_n,
    output logic            lb_wr_n,
    output logic [DW-1:0]   lb_data_o,
    output logic            lb_data_oe,
    input  logic [DW-1:0]   lb_data_i
);

    lbus_state_e    state;
    logic           start, wr_q, capture;
    logic [CSW-1:0] sel_q;
    logic [DW-1:0]  wdata_q;

    assign start = req_valid && (state == ST_IDLE);
    assign busy  = (state != ST_IDLE);

    lbus_fsm #(.TW(TW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .req_write  (req_write),
        .cfg_setup  (cfg_setup),
        .cfg_rd_len (cfg_rd_len),
        .cfg_wr_len (cfg_wr_len),
        .cfg_hold   (cfg_hold),
        .cfg_dhold  (cfg_dhold),
        .state      (state),
        .wr_q       (wr_q),
        .capture    (capture),
        .done       (done)
    );

    lbus_addr #(.AW(AW), .WINW(WINW)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .req_addr (req_addr),
        .cfg_win  (cfg_win),
        .addr_q   (lb_addr)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q   <= '0;
            wdata_q <= '0;
            rd_data <= '0;
        end else begin
            if (start) sel_q <= req_sel;
            if (start && req_write) wdata_q <= req_wdata;
            if (capture) rd_data <= lb_data_i;
        end
    end

    lbus_pins #(.NCS(NCS), .CSW(CSW), .DW(DW)) u_pins (
        .state          (state),
        .wr_q           (wr_q),
        .sel_q          (sel_q),
        .cfg_moto       (cfg_moto),
        .cfg_idle_drive (cfg_idle_drive),
        .wdata_q        (wdata_q),
        .lb_cs_n        (lb_cs_n),
        .lb_rd_n        (lb_rd_n),
        .lb_wr_n        (lb_wr_n),
        .lb_data_o      (lb_data_o),
        .lb_data_oe     (lb_data_oe)
    );

endmodule

// File: rtl/lbus_seq_chk.sv
module lbus_seq_chk #(
    parameter int AW   = 12,
    parameter int NCS  = 4,
    parameter int WINW = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            done,
    input logic [AW-1:0]   lb_addr,
    input logic [NCS-1:0]  lb_cs_n,
    input logic            lb_rd_n,
    input logic            lb_wr_n,
    input logic            cfg_moto,
    input logic [WINW-1:0] cfg_win
);

    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (&lb_cs_n && lb_rd_n && lb_wr_n));

    assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_one_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~lb_cs_n));

    assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_moto |-> (lb_rd_n || lb_wr_n));

    assert_no_rd_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_moto |-> lb_rd_n);

    assert_addr_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(lb_addr));

    assert_addr_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ((lb_addr >> cfg_win) == '0));

endmodule

bind lbus_seq lbus_seq_chk #(.AW(AW), .NCS(NCS), .WINW(WINW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .lb_addr  (lb_addr),
    .lb_cs_n  (lb_cs_n),
    .lb_rd_n  (lb_rd_n),
    .lb_wr_n  (lb_wr_n),
    .cfg_moto (cfg_moto),
    .cfg_win  (cfg_win)
);

// File: tb/lbus_seq_bench.sv
`timescale 1ns/1ps
module lbus_seq_bench;

    localparam int DW = 32;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [1:0]    req_sel = '0;
    logic          cfg_moto = 1'b0, cfg_idle_drive = 1'b0;
    logic [3:0]    cfg_win = 4'd12;
    logic [3:0]    cfg_setup = '0, cfg_rd_len = '0, cfg_wr_len = '0, cfg_hold = '0, cfg_dhold = '0;
    logic          busy, done, lb_rd_n, lb_wr_n, lb_data_oe;
    logic [DW-1:0] rd_data, lb_data_o, lb_data_i, periph;
    logic [AW-1:0] lb_addr;
    logic [3:0]    lb_cs_n;

    int vectors = 0;
    int fails   = 0;
    logic [DW-1:0] last_wdata = '0;
    logic [DW-1:0] last_rdata = '0;

    always #2 clk = ~clk;

    // peripheral returns periph only while a strobe is asserted
    assign lb_data_i = (cfg_moto ? (lb_cs_n != 4'hF) : !lb_rd_n) ? periph : ~periph;

    lbus_seq u_lbus_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_sel(req_sel),
        .cfg_moto(cfg_moto), .cfg_idle_drive(cfg_idle_drive), .cfg_win(cfg_win),
        .cfg_setup(cfg_setup), .cfg_rd_len(cfg_rd_len), .cfg_wr_len(cfg_wr_len),
        .cfg_hold(cfg_hold), .cfg_dhold(cfg_dhold), .busy(busy), .done(done),
        .rd_data(rd_data), .lb_addr(lb_addr), .lb_cs_n(lb_cs_n), .lb_rd_n(lb_rd_n),
        .lb_wr_n(lb_wr_n), .lb_data_o(lb_data_o), .lb_data_oe(lb_data_oe),
        .lb_data_i(lb_data_i)
    );

    task automatic chk(input bit ok, input string req, input longint got, input longint exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
        end
    endtask

    function automatic logic [AW-1:0] mask_addr(input logic [AW-1:0] a, input int win);
        logic [AW-1:0] r = a;
        for (int i = 0; i < AW; i++) if (i >= win) r[i] = 1'b0;
        return r;
    endfunction

    // 0 setup, 1 strobe, 2 hold, 3 data hold
    function automatic int phase_of(input int k, input int s, input int w, input int h);
        if (k < s) return 0;
        if (k < s + w) return 1;
        if (k < s + w + h) return 2;
        return 3;
    endfunction

    task automatic idle_check(input string tag);
        chk(&lb_cs_n && lb_rd_n && lb_wr_n, "R6", {lb_cs_n, lb_rd_n, lb_wr_n}, 6'h3F);
        chk(lb_data_oe == cfg_idle_drive, "R9", lb_data_oe, cfg_idle_drive);
        if (cfg_idle_drive) chk(lb_data_o == last_wdata, "R9", lb_data_o, last_wdata);
    endtask

    // called at a negedge with the design idle; returns at the completion negedge
    task automatic run_one(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                           input logic [1:0] sel, input bit moto, input bit idrv,
                           input logic [3:0] win, input logic [3:0] s, input logic [3:0] rl,
                           input logic [3:0] wl, input logic [3:0] h, input logic [3:0] dh,
                           input bit junk);
        int w, d, total, k, ph;
        logic [AW-1:0] ea;
        logic [3:0] ecs;
        bit erd, ewr;
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = wd; req_sel = sel;
        cfg_moto = moto; cfg_idle_drive = idrv; cfg_win = win;
        cfg_setup = s; cfg_rd_len = rl; cfg_wr_len = wl; cfg_hold = h; cfg_dhold = dh;
        periph = $urandom;
        w = wr ? int'(wl) : int'(rl);
        if (w == 0) w = 1;
        d = wr ? int'(dh) : 0;
        total = int'(s) + w + int'(h) + d;
        ea = mask_addr(a, int'(win));
        @(posedge clk);
        @(negedge clk);
        req_valid = junk;
        k = 0;
        while (busy && k < 100) begin
            if (junk) begin
                req_addr = $urandom; req_wdata = $urandom; req_write = $urandom; req_sel = $urandom;
            end
            ph = phase_of(k, int'(s), w, int'(h));
            if (!moto) begin
                ecs = (ph <= 2) ? ~(4'b1 << sel) : 4'hF;
                erd = !(ph == 1 && !wr);
                ewr = !(ph == 1 && wr);
                chk(lb_cs_n == ecs, "R4", lb_cs_n, ecs);
                chk({lb_rd_n, lb_wr_n} == {erd, ewr}, "R4", {lb_rd_n, lb_wr_n}, {erd, ewr});
            end else begin
                ecs = (ph == 1) ? ~(4'b1 << sel) : 4'hF;
                ewr = !(wr && ph <= 2);
                chk(lb_cs_n == ecs, "R5", lb_cs_n, ecs);
                chk({lb_rd_n, lb_wr_n} == {1'b1, ewr}, "R5", {lb_rd_n, lb_wr_n}, {1'b1, ewr});
            end
            chk(lb_data_oe == wr, "R8", lb_data_oe, wr);
            if (wr) chk(lb_data_o == wd, "R8", lb_data_o, wd);
            chk(lb_addr == ea, "R10", lb_addr, ea);
            k++;
            @(negedge clk);
        end
        req_valid = 0;
        chk(k == total, "R3", k, total);
        chk(done == 1'b1, "R2", done, 1);
        chk(lb_addr == ea, "R10", lb_addr, ea);
        if (wr) last_wdata = wd;
        else    last_rdata = periph;
        chk(rd_data == last_rdata, "R7", rd_data, last_rdata);
        idle_check("R9");
    endtask

    task automatic rand_one(input bit junk);
        run_one($urandom_range(0, 1), AW'($urandom), $urandom, 2'($urandom),
                $urandom_range(0, 1), $urandom_range(0, 1), 4'($urandom_range(0, 13)),
                4'($urandom), 4'($urandom), 4'($urandom), 4'($urandom), 4'($urandom), junk);
    endtask

    initial begin
        void'($urandom(32'h1D6A_0C45));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk(!busy && !done, "R1", {busy, done}, 0);
        chk(rd_data == '0, "R1", rd_data, 0);
        chk(&lb_cs_n && lb_rd_n && lb_wr_n, "R1", {lb_cs_n, lb_rd_n, lb_wr_n}, 6'h3F);
        chk(lb_data_oe == 1'b0, "R1", lb_data_oe, 0);

        // R3: all-zero fields give a one-cycle strobe, no other phases
        run_one(1, 12'hABC, 32'h1234_5678, 2'd1, 0, 0, 4'd12, 0, 0, 0, 0, 0, 0);
        run_one(0, 12'h0F3, 32'h0, 2'd2, 0, 1, 4'd12, 0, 0, 0, 0, 0, 0);
        // R3/R8: every phase at maximum, write and read
        run_one(1, 12'hFFF, 32'hDEAD_BEEF, 2'd3, 0, 1, 4'd12, 15, 15, 15, 15, 15, 0);
        run_one(0, 12'h555, 32'h0, 2'd0, 0, 0, 4'd12, 15, 15, 15, 15, 15, 0);
        // R5: data-strobe convention, read and write
        run_one(1, 12'h321, 32'hCAFE_F00D, 2'd2, 1, 0, 4'd12, 2, 1, 3, 2, 4, 0);
        run_one(0, 12'h321, 32'h0, 2'd3, 1, 1, 4'd12, 3, 2, 1, 1, 4, 0);
        // R10: narrow windows, including zero
        run_one(0, 12'hFFF, 32'h0, 2'd0, 0, 0, 4'd0, 1, 1, 1, 1, 1, 0);
        run_one(1, 12'hFFF, 32'h0BAD_0001, 2'd1, 0, 0, 4'd5, 1, 2, 2, 0, 0, 0);
        // R2: requests while busy are ignored
        run_one(1, 12'h777, 32'h7777_7777, 2'd1, 0, 1, 4'd12, 2, 3, 3, 2, 2, 1);
        @(negedge clk);
        chk(!busy, "R2", busy, 0);
        idle_check("R9");

        // randomized accesses, mostly back to back, some with idle gaps
        for (int n = 0; n < 300; n++) begin
            rand_one($urandom_range(0, 9) == 0);
            if ($urandom_range(0, 3) == 0) begin
                repeat ($urandom_range(1, 3)) begin
                    @(negedge clk);
                    chk(!busy && !done, "R2", {busy, done}, 0);
                    idle_check("R9");
                end
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule